// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address into a physical frame after a translation cache miss, using 32-bit two-level paging without physical address extension. Given a request carrying the virtual address, a write flag and a user flag, it fetches the directory entry and, unless that entry maps a 4 MB page, the table entry. Both reads go through a single pulse-request, delayed-response memory port. It merges and checks the protection bits, writes the accessed and dirty bits back to memory, and then reports either a translation or a page fault.

A translation gives the physical frame number of the 4 KB region that holds the address, a write-permission flag and a large-page flag. A fault gives a three-bit error code and the faulting address. The configuration inputs (paging enable, supervisor write protect, large-page enable, directory base, address mask) must stay stable while a walk is in progress. Each memory request is a one-cycle pulse, and each request receives exactly one one-cycle response. For a write, the response only acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, an accepted request completes with no memory access: frame = va[31:12] AND mask[31:12], write permission 1, large-page flag 0.
- R2: The first read of a walk is at ((base AND 0xFFFFF000) + va[31:22]*4) AND mask.
- R3: For a 4 KB walk, the second read is at ((directory entry AND 0xFFFFF000) + va[21:12]*4) AND mask. The frame is entry[31:12] AND mask[31:12].
- R4: A present directory entry with bit 7 (page size) set, while large pages are enabled, maps a 4 MB page with no second read. The frame is {entry[31:22] AND mask[31:22], va[21:12]} and the large-page flag is 1. With large pages disabled, bit 7 is ignored and the walk reads a table entry.
- R5: For a 4 KB page, the user bit (bit 2) and the read/write bit (bit 1) that are checked are the AND of the directory and table entries.
- R6: A user access faults when the effective user bit is 0, or when it writes and the effective read/write bit is 0. A supervisor write faults only when write protect is on and the effective read/write bit is 0. Supervisor reads never fault on protection.
- R7: A directory entry that points to a table is written back with bit 5 (accessed) set when that bit was clear. The final entry is written back with bit 5 set, and also bit 6 (dirty) on a write, when bit 5 was clear or a write finds bit 6 clear. Otherwise nothing is written.
- R8: A fault reports code bit 0 = 1 for a protection fault and 0 for a not-present one (bit 0 of an entry clear), code bit 1 = the write flag, code bit 2 = the user flag, and the faulting address = the request address. A fault makes no write-back of the faulting entry.
- R9: Write permission is reported as 1 only when the final entry is dirty after the walk and the user / write-protect rule permits writing.
- R10: req_ready is high only in the idle state, and a request presented while it is low is ignored. Each accepted request produces exactly one one-cycle pulse on done_valid or fault_valid, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Write protect for supervisor accesses |
| cfg_pse | input | 1 | Large (4 MB) page enable |
| cfg_root | input | 32 | Directory base address |
| cfg_a20_mask | input | 32 | Mask ANDed into entry addresses and frames |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response / acknowledge pulse |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Translation result pulse |
| done_frame | output | 20 | Physical frame of the 4 KB region |
| done_write_ok | output | 1 | Writes may use this mapping |
| done_big | output | 1 | Mapping comes from a 4 MB page |
| fault_valid | output | 1 | Page fault pulse |
| fault_code | output | 3 | {user, write, protection} |
| fault_addr | output | 32 | Faulting virtual address |

## Verification
On every cycle, the assertions check the handshake rules: done and fault are exclusive single-cycle pulses, nothing completes while the walker is idle, memory requests are single pulses, every write-back carries the accessed bit, and an unpaged request finishes on the next cycle without touching memory. Everything that depends on table contents has to be shown by the bench's scenarios. That covers the computed entry addresses, the AND of the protection bits across levels, the write-protect rule, the exact write-back values and when they are skipped, the fault codes, the 4 MB frames, and bit 7 being ignored when large pages are off.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WB_DIR,
    ST_RD_TBL,
    ST_WB_FIN,
    ST_DONE,
    ST_FAULT
  } walk_st_t;

  // entry bit positions, fixed by the table format
  localparam int E_P  = 0;
  localparam int E_RW = 1;
  localparam int E_US = 2;
  localparam int E_A  = 5;
  localparam int E_D  = 6;
  localparam int E_PS = 7;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic [VA_W-1:0] root,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] dir_ent,
  input  logic [VA_W-1:0] a20_mask,
  output logic [VA_W-1:0] dir_addr,
  output logic [VA_W-1:0] tbl_addr
);
  localparam int DIR_LSB = PAGE_SHIFT + IDX_W;
  localparam logic [VA_W-1:0] BASE_MASK = {{(VA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};

  logic [VA_W-1:0] dir_off, tbl_off;

  always_comb begin
    dir_off  = VA_W'(va[VA_W-1:DIR_LSB]) << 2;
    tbl_off  = VA_W'(va[DIR_LSB-1:PAGE_SHIFT]) << 2;
    dir_addr = ((root & BASE_MASK) + dir_off) & a20_mask;
    tbl_addr = ((dir_ent & BASE_MASK) + tbl_off) & a20_mask;
  end
endmodule

// File: rtl/pw_perm.sv
module pw_perm (
  input  logic is_user,
  input  logic is_write,
  input  logic wp_on,
  input  logic us_bit,
  input  logic rw_bit,
  output logic deny,
  output logic wr_grant
);
  always_comb begin
    if (is_user) begin
      deny     = !us_bit || (is_write && !rw_bit);
      wr_grant = rw_bit;
    end else begin
      deny     = wp_on && is_write && !rw_bit;
      wr_grant = !wp_on || rw_bit;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_paging,
  input  logic                     cfg_wp,
  input  logic                     cfg_pse,
  input  logic [VA_W-1:0]          cfg_root,
  input  logic [VA_W-1:0]          cfg_a20_mask,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_va,
  input  logic                     req_write,
  input  logic                     req_user,
  output logic                     mem_req_valid,
  output logic                     mem_req_write,
  output logic [VA_W-1:0]          mem_req_addr,
  output logic [VA_W-1:0]          mem_req_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [VA_W-1:0]          mem_rsp_rdata,
  output logic                     done_valid,
  output logic [VA_W-PAGE_SHIFT-1:0] done_frame,
  output logic                     done_write_ok,
  output logic                     done_big,
  output logic                     fault_valid,
  output logic [2:0]               fault_code,
  output logic [VA_W-1:0]          fault_addr
);
  localparam int DIR_LSB = PAGE_SHIFT + IDX_W;
  localparam logic [VA_W-1:0] A_BIT = VA_W'(1) << E_A;
  localparam logic [VA_W-1:0] D_BIT = VA_W'(1) << E_D;

  walk_st_t        state;
  logic [VA_W-1:0] va_q, pde_q;
  logic            wr_q, usr_q;

  logic [VA_W-1:0] va_sel, ent_sel, eff_ent;
  logic [VA_W-1:0] dir_addr, tbl_addr;
  logic            deny, wr_grant;
  logic            fin_dirty, fin_wb;

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    va_sel    = (state == ST_IDLE) ? req_va : va_q;
    ent_sel   = (state == ST_RD_DIR) ? mem_rsp_rdata : pde_q;
    eff_ent   = (state == ST_RD_TBL) ? (mem_rsp_rdata & pde_q) : mem_rsp_rdata;
    fin_dirty = mem_rsp_rdata[E_D] | wr_q;
    fin_wb    = !mem_rsp_rdata[E_A] || (wr_q && !mem_rsp_rdata[E_D]);
  end

  pw_addr_gen #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) u_addr (
    .root(cfg_root), .va(va_sel), .dir_ent(ent_sel), .a20_mask(cfg_a20_mask),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr)
  );

  pw_perm u_perm (
    .is_user(usr_q), .is_write(wr_q), .wp_on(cfg_wp),
    .us_bit(eff_ent[E_US]), .rw_bit(eff_ent[E_RW]),
    .deny(deny), .wr_grant(wr_grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      va_q          <= '0;
      pde_q         <= '0;
      wr_q          <= 1'b0;
      usr_q         <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      done_valid    <= 1'b0;
      done_frame    <= '0;
      done_write_ok <= 1'b0;
      done_big      <= 1'b0;
      fault_valid   <= 1'b0;
      fault_code    <= '0;
      fault_addr    <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done_valid    <= 1'b0;
      fault_valid   <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          usr_q <= req_user;
          if (!cfg_paging) begin
            done_frame    <= req_va[VA_W-1:PAGE_SHIFT] & cfg_a20_mask[VA_W-1:PAGE_SHIFT];
            done_write_ok <= 1'b1;
            done_big      <= 1'b0;
            done_valid    <= 1'b1;
            state         <= ST_DONE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= dir_addr;
            state         <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: if (mem_rsp_valid) begin
          pde_q <= mem_rsp_rdata;
          if (!mem_rsp_rdata[E_P]) begin
            fault_valid <= 1'b1;
            fault_code  <= {usr_q, wr_q, 1'b0};
            fault_addr  <= va_q;
            state       <= ST_FAULT;
          end else if (mem_rsp_rdata[E_PS] && cfg_pse) begin
            if (deny) begin
              fault_valid <= 1'b1;
              fault_code  <= {usr_q, wr_q, 1'b1};
              fault_addr  <= va_q;
              state       <= ST_FAULT;
            end else begin
              done_frame    <= {mem_rsp_rdata[VA_W-1:DIR_LSB] & cfg_a20_mask[VA_W-1:DIR_LSB],
                                va_q[DIR_LSB-1:PAGE_SHIFT]};
              done_big      <= 1'b1;
              done_write_ok <= fin_dirty & wr_grant;
              if (fin_wb) begin
                mem_req_valid <= 1'b1;
                mem_req_write <= 1'b1;
                mem_req_addr  <= dir_addr;
                mem_req_wdata <= mem_rsp_rdata | A_BIT | (wr_q ? D_BIT : '0);
                state         <= ST_WB_FIN;
              end else begin
                done_valid <= 1'b1;
                state      <= ST_DONE;
              end
            end
          end else if (!mem_rsp_rdata[E_A]) begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b1;
            mem_req_addr  <= dir_addr;
            mem_req_wdata <= mem_rsp_rdata | A_BIT;
            state         <= ST_WB_DIR;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= tbl_addr;
            state         <= ST_RD_TBL;
          end
        end
        ST_WB_DIR: if (mem_rsp_valid) begin
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b0;
          mem_req_addr  <= tbl_addr;
          state         <= ST_RD_TBL;
        end
        ST_RD_TBL: if (mem_rsp_valid) begin
          if (!mem_rsp_rdata[E_P] || deny) begin
            fault_valid <= 1'b1;
            fault_code  <= {usr_q, wr_q, mem_rsp_rdata[E_P]};
            fault_addr  <= va_q;
            state       <= ST_FAULT;
          end else begin
            done_frame    <= mem_rsp_rdata[VA_W-1:PAGE_SHIFT] & cfg_a20_mask[VA_W-1:PAGE_SHIFT];
            done_big      <= 1'b0;
            done_write_ok <= fin_dirty & wr_grant;
            if (fin_wb) begin
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b1;
              mem_req_addr  <= tbl_addr;
              mem_req_wdata <= mem_rsp_rdata | A_BIT | (wr_q ? D_BIT : '0);
              state         <= ST_WB_FIN;
            end else begin
              done_valid <= 1'b1;
              state      <= ST_DONE;
            end
          end
        end
        ST_WB_FIN: if (mem_rsp_valid) begin
          done_valid <= 1'b1;
          state      <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_paging,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_write,
  input logic [VA_W-1:0] mem_req_wdata,
  input logic            done_valid,
  input logic            fault_valid
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && fault_valid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!done_valid && !fault_valid));

  p_unpaged_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cfg_paging) |=> (done_valid && !mem_req_valid));

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_wb_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]);
endmodule

bind pt_walker pw_checker #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_paging(cfg_paging), .req_valid(req_valid),
  .req_ready(req_ready), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_req_wdata(mem_req_wdata), .done_valid(done_valid), .fault_valid(fault_valid)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst, cfg_paging, cfg_wp, cfg_pse;
  logic [31:0] cfg_root, cfg_a20_mask;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_va;
  logic        mem_req_valid, mem_req_write, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic        done_valid, done_write_ok, done_big, fault_valid;
  logic [19:0] done_frame;
  logic [2:0]  fault_code;
  logic [31:0] fault_addr;

  pt_walker dut (
    .clk(clk), .rst(rst), .cfg_paging(cfg_paging), .cfg_wp(cfg_wp), .cfg_pse(cfg_pse),
    .cfg_root(cfg_root), .cfg_a20_mask(cfg_a20_mask), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_frame(done_frame), .done_write_ok(done_write_ok),
    .done_big(done_big), .fault_valid(fault_valid), .fault_code(fault_code),
    .fault_addr(fault_addr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // memory model: word array indexed by addr[13:2], two-cycle response
  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:7];
  logic [31:0] log_data [0:7];
  logic        log_wr   [0:7];
  int          n_log;
  int          lat;
  logic [31:0] pend;

  function automatic int wi(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    lat = 0;
    pend = '0;
    n_log = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pend;
        end
      end
      if (mem_req_valid) begin
        if (n_log < 8) begin
          log_addr[n_log] = mem_req_addr;
          log_data[n_log] = mem_req_wdata;
          log_wr[n_log]   = mem_req_write;
        end
        n_log++;
        if (mem_req_write) begin
          mem[wi(mem_req_addr)] = mem_req_wdata;
          pend = '0;
        end else begin
          pend = mem[wi(mem_req_addr)];
        end
        lat = 2;
      end
    end
  end

  // results of the last walk
  logic        r_done, r_fault, r_ok, r_big, r_pulse;
  logic [19:0] r_frame;
  logic [2:0]  r_code;
  logic [31:0] r_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic w, input logic u, input logic poke);
    n_log = 0;
    @(negedge clk);
    req_va    = va;
    req_write = w;
    req_user  = u;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk("R10 ready low mid-walk", {31'b0, req_ready}, 32'd0);
      req_va    = va ^ 32'h0040_0000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_va    = va;
    end
    r_done = 1'b0;
    r_fault = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_valid || fault_valid) break;
      @(negedge clk);
    end
    r_done  = done_valid;
    r_fault = fault_valid;
    r_ok    = done_write_ok;
    r_big   = done_big;
    r_frame = done_frame;
    r_code  = fault_code;
    r_addr  = fault_addr;
    @(negedge clk);
    r_pulse = !done_valid && !fault_valid;
    chk("R10 single pulse", {31'b0, r_pulse}, 32'd1);
    chk("R10 one outcome", {30'b0, r_done, r_fault} == 2'b00 ? 32'd0 : 32'd1, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R10 reset done", {31'b0, done_valid}, 32'd0);
    chk("R10 reset fault", {31'b0, fault_valid}, 32'd0);
    chk("R2 reset mem idle", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_unpaged();
    cfg_paging = 1'b0;
    cfg_a20_mask = 32'hFFFF_FFFF;
    walk(32'h1234_5678, 1'b1, 1'b1, 1'b0);
    chk("R1 done", {31'b0, r_done}, 32'd1);
    chk("R1 frame", {12'b0, r_frame}, 32'h12345);
    chk("R1 write ok", {31'b0, r_ok}, 32'd1);
    chk("R1 small page", {31'b0, r_big}, 32'd0);
    chk("R1 no memory access", n_log, 0);
    cfg_a20_mask = 32'hFFEF_FFFF;
    walk(32'h0012_3456, 1'b0, 1'b0, 1'b0);
    chk("R1 masked frame", {12'b0, r_frame}, 32'h00023);
    cfg_a20_mask = 32'hFFFF_FFFF;
    cfg_paging = 1'b1;
  endtask

  task automatic t_walk4k();
    // directory at 0x1000, entry 1 points at table 0x2000, accessed clear
    mem[wi(32'h1004)] = 32'h0000_2007;
    mem[wi(32'h200C)] = 32'h0005_5067;
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b1);
    chk("R2 dir read addr", log_addr[0], 32'h1004);
    chk("R7 dir wb addr", log_addr[1], 32'h1004);
    chk("R7 dir wb is write", {31'b0, log_wr[1]}, 32'd1);
    chk("R7 dir wb data", log_data[1], 32'h0000_2027);
    chk("R3 table read addr", log_addr[2], 32'h200C);
    chk("R7 no final wb when clean", n_log, 3);
    chk("R3 frame", {12'b0, r_frame}, 32'h00055);
    chk("R9 dirty write ok", {31'b0, r_ok}, 32'd1);
    chk("R10 stray request ignored", {31'b0, r_done}, 32'd1);
    // dir entry now accessed: no write-back on a second walk
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0);
    chk("R7 no dir wb when accessed", n_log, 2);
    // masked base: 0x101000 & 0xFFEFFFFF selects 0x1000
    cfg_root = 32'h0010_1000;
    cfg_a20_mask = 32'hFFEF_FFFF;
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0);
    chk("R2 masked dir addr", log_addr[0], 32'h1004);
    chk("R2 masked walk frame", {12'b0, r_frame}, 32'h00055);
    cfg_root = 32'h0000_1000;
    cfg_a20_mask = 32'hFFFF_FFFF;
  endtask

  task automatic t_dirty();
    mem[wi(32'h2010)] = 32'h0006_6007;
    walk(32'h0040_4000, 1'b0, 1'b0, 1'b0);
    chk("R7 read sets accessed only", mem[wi(32'h2010)], 32'h0006_6027);
    chk("R9 clean entry no write", {31'b0, r_ok}, 32'd0);
    walk(32'h0040_4000, 1'b1, 1'b1, 1'b0);
    chk("R7 write sets dirty", mem[wi(32'h2010)], 32'h0006_6067);
    chk("R9 write grants", {31'b0, r_ok}, 32'd1);
    chk("R7 final wb count", n_log, 3);
  endtask

  task automatic t_perm();
    // dir entry 2: no user bit; table entry has user bit
    mem[wi(32'h1008)] = 32'h0000_3023;
    mem[wi(32'h3004)] = 32'h0007_7067;
    walk(32'h0080_1234, 1'b0, 1'b1, 1'b0);
    chk("R5 user denied by dir", {31'b0, r_fault}, 32'd1);
    chk("R8 code user prot", {29'b0, r_code}, 32'd5);
    chk("R8 fault addr", r_addr, 32'h0080_1234);
    chk("R8 no write on fault", n_log, 2);
    walk(32'h0080_1234, 1'b1, 1'b0, 1'b0);
    chk("R6 supervisor ignores user bit", {31'b0, r_done}, 32'd1);
    // dir entry 3: user, read-only; table entry read-only dirty
    mem[wi(32'h100C)] = 32'h0000_4025;
    mem[wi(32'h4000)] = 32'h0008_8065;
    cfg_wp = 1'b0;
    walk(32'h00C0_0000, 1'b1, 1'b0, 1'b0);
    chk("R6 sup write wp off", {31'b0, r_done}, 32'd1);
    chk("R9 sup wp off write ok", {31'b0, r_ok}, 32'd1);
    cfg_wp = 1'b1;
    walk(32'h00C0_0000, 1'b1, 1'b0, 1'b0);
    chk("R6 sup write wp on faults", {31'b0, r_fault}, 32'd1);
    chk("R8 code write prot", {29'b0, r_code}, 32'd3);
    walk(32'h00C0_0000, 1'b0, 1'b0, 1'b0);
    chk("R9 wp on read-only no write", {31'b0, r_ok}, 32'd0);
    walk(32'h00C0_0000, 1'b1, 1'b1, 1'b0);
    chk("R6 user write read-only", {29'b0, r_code}, 32'd7);
    cfg_wp = 1'b0;
    walk(32'h00C0_0000, 1'b0, 1'b1, 1'b0);
    chk("R9 user read-only no write", {31'b0, r_ok}, 32'd0);
    // not present at both levels
    walk(32'h0140_0000, 1'b0, 1'b0, 1'b0);
    chk("R8 dir not present", {28'b0, r_fault, r_code}, 32'h8);
    walk(32'h0140_0000, 1'b1, 1'b1, 1'b0);
    chk("R8 dir not present user write", {29'b0, r_code}, 32'd6);
    walk(32'h0040_5000, 1'b0, 1'b1, 1'b0);
    chk("R8 table not present", {28'b0, r_fault, r_code}, 32'hC);
  endtask

  task automatic t_big();
    cfg_pse = 1'b1;
    mem[wi(32'h1018)] = 32'h0A00_0087;
    walk(32'h0198_7654, 1'b0, 1'b0, 1'b0);
    chk("R4 big frame", {12'b0, r_frame}, 32'h0A187);
    chk("R4 big flag", {31'b0, r_big}, 32'd1);
    chk("R4 one read one wb", n_log, 2);
    chk("R7 big wb data", mem[wi(32'h1018)], 32'h0A00_00A7);
    chk("R9 big clean no write", {31'b0, r_ok}, 32'd0);
    cfg_pse = 1'b0;
    walk(32'h0198_7654, 1'b0, 1'b0, 1'b0);
    chk("R4 size bit ignored", log_addr[1], 32'h0A00_061C);
    chk("R4 ignored gives table fault", {28'b0, r_fault, r_code}, 32'h8);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL R10 watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    rst = 1'b1;
    cfg_paging = 1'b1;
    cfg_wp = 1'b0;
    cfg_pse = 1'b0;
    cfg_root = 32'h0000_1000;
    cfg_a20_mask = 32'hFFFF_FFFF;
    req_valid = 1'b0;
    req_va = '0;
    req_write = 1'b0;
    req_user = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unpaged();
    t_walk4k();
    t_dirty();
    t_perm();
    t_big();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule